// File: doc/BRIEF.md
# Receive Byte Buffer with Sender Throttling

This block sits between a UART receiver and a slow consumer, such as a flash programming engine. It stores every received byte in a 256-entry ring, together with three line-error bits (parity, framing, break). It also throttles the far-end sender so that bytes already in flight still find room. A programmable upper mark starts throttling and a lower mark ends it. Between the two marks the throttle state does not change, so the throttle has hysteresis.

Two throttling modes exist. In pin mode the block drives a stop level. This signal is high to hold the sender and low to let it transmit, and an external inverting line driver makes it active-low at the connector. In character mode the pin stays low. Instead, the block asks the local transmitter to send an in-band XOFF (0x13) or XON (0x11). That mode suits text payloads only, where every data byte is 32 or above.

The upper mark should sit below 256 by the number of characters the sender may still push after it is told to stop. That is at least one character, and up to 16 when the sender drains its own FIFO. Bytes enter with a one-cycle valid strobe and cannot be back-pressured. Bytes leave on a valid/ready stream. A byte is taken only in a cycle where both are high. While valid is high and ready is low, the data and error bits do not change. Valid never drops until the byte is taken.

Top module: `rx_throttle_buf`

## Requirements
- R1: A synchronous active-high reset empties the buffer. It leaves `fill_level` 0, `out_valid` 0, `cts_stop` 0, `xreq_valid` 0 and `overrun` 0.
- R2: Bytes leave in arrival order, each with its own 3 error bits. `out_valid` is high exactly when the buffer is not empty. An entry is removed only on a cycle with `out_valid` and `out_ready` both high, and it stays stable until then.
- R3: `fill_level` reports the number of stored entries, from 0 to 256. An accepted byte raises it by one and a taken byte lowers it by one. Both in the same cycle leave it unchanged.
- R4: A byte strobed in while `fill_level` is 256 is dropped, even if a byte is taken in that cycle, and it sets the sticky `overrun` flag. A cycle with `overrun_clr` high clears the flag, unless a new drop happens in that same cycle, in which case the flag stays set.
- R5: Throttle state: it goes to stop on the clock edge after a cycle in which `fill_level` >= `hi_mark`. It returns to go on the edge after a cycle in which `fill_level` <= `lo_mark`. Otherwise it holds. In pin mode (`mode_sw` = 0), `cts_stop` equals this state.
- R6: In character mode (`mode_sw` = 1), `cts_stop` stays 0. Each change of the throttle state raises `xreq_valid` on the same edge, with `xreq_char` = 0x13 for a change to stop or 0x11 for a change to go. The request holds until a cycle with `xreq_ack` high takes it.
- R7: At most one request is pending. A throttle change while a request is still pending replaces it with the new character, and this wins over an `xreq_ack` in the same cycle.
- R8: The read and write positions wrap from 255 to 0 with no loss of order when more than 256 bytes pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sw | input | 1 | 0 = pin throttling, 1 = XON/XOFF characters |
| hi_mark | input | 9 | Fill level that starts throttling |
| lo_mark | input | 9 | Fill level that ends throttling (below hi_mark) |
| in_valid | input | 1 | Received byte strobe from the UART |
| in_data | input | 8 | Received byte |
| in_err | input | 3 | Error bits of the received byte: parity, framing, break |
| out_valid | output | 1 | A stored byte is offered |
| out_ready | input | 1 | Consumer takes the offered byte |
| out_data | output | 8 | Offered byte |
| out_err | output | 3 | Error bits of the offered byte |
| fill_level | output | 9 | Number of stored entries |
| cts_stop | output | 1 | Sender stop level (high = stop), pin mode only |
| xreq_valid | output | 1 | Flow character waiting for the transmitter |
| xreq_char | output | 8 | 0x13 (XOFF) or 0x11 (XON) |
| xreq_ack | input | 1 | Transmitter has taken the flow character |
| overrun | output | 1 | Sticky: a byte was dropped on a full buffer |
| overrun_clr | input | 1 | Clears `overrun` |

## Verification
A reference queue in the bench runs in lockstep with the design under several traffic mixes. A balanced mix keeps the level near the middle and wraps the positions many times, which shows up any loss of order. A fast-in, slow-out mix drives the level to 256. There, drops and the overrun flag show whether the capacity edge and the set-over-clear priority are right. Close marks (4 and 3) with a slow acknowledger make XOFF and XON follow each other before they are taken, which exposes how a pending request is replaced. Wide marks show the hysteresis: the throttle must hold across the whole band between the marks.

// File: rtl/rx_throttle_pkg.sv
package rx_throttle_pkg;
  localparam logic [7:0] CH_XOFF = 8'h13;
  localparam logic [7:0] CH_XON  = 8'h11;
  localparam int ERR_W = 3;

  typedef struct packed {
    logic [ERR_W-1:0] err;
    logic [7:0]       data;
  } rx_entry_t;
endpackage

// File: rtl/rtb_ring.sv
module rtb_ring
  import rx_throttle_pkg::*;
#(
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  rx_entry_t     push_ent,
  input  logic          pop_req,
  output rx_entry_t     head_ent,
  output logic          not_empty,
  output logic          is_full,
  output logic [CW-1:0] level,
  output logic          dropped
);
  rx_entry_t       store [DEPTH];
  logic [AW-1:0]   wr_pos, rd_pos;
  logic [CW-1:0]   cnt_q;
  logic            do_push, do_pop;

  assign not_empty = (cnt_q != '0);
  assign is_full   = (cnt_q == CW'(DEPTH));
  assign do_push   = push_req && !is_full;
  assign do_pop    = pop_req && not_empty;
  assign dropped   = push_req && is_full;
  assign head_ent  = store[rd_pos];
  assign level     = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) store[wr_pos] <= push_ent;
  end

  // position registers wrap by overflow of their own width
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pos <= '0;
      rd_pos <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_pos <= wr_pos + 1'b1;
      if (do_pop)  rd_pos <= rd_pos + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rtb_flow.sv
module rtb_flow
  import rx_throttle_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_sw,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] hi_mark,
  input  logic [CW-1:0] lo_mark,
  input  logic          req_ack,
  output logic          hold_q,
  output logic          req_valid,
  output logic [7:0]    req_char
);
  logic hold_n;

  always_comb begin
    if (hold_q) hold_n = !(level <= lo_mark);
    else        hold_n = (level >= hi_mark);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b0;
      req_valid <= 1'b0;
      req_char  <= CH_XON;
    end else begin
      hold_q <= hold_n;
      if (mode_sw && (hold_n != hold_q)) begin
        req_valid <= 1'b1;
        req_char  <= hold_n ? CH_XOFF : CH_XON;
      end else if (req_valid && req_ack) begin
        req_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_throttle_buf.sv
module rx_throttle_buf
  import rx_throttle_pkg::*;
#(
  parameter int AW = 8,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_sw,
  input  logic [CW-1:0] hi_mark,
  input  logic [CW-1:0] lo_mark,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic [2:0]    in_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic [2:0]    out_err,
  output logic [CW-1:0] fill_level,
  output logic          cts_stop,
  output logic          xreq_valid,
  output logic [7:0]    xreq_char,
  input  logic          xreq_ack,
  output logic          overrun,
  input  logic          overrun_clr
);
  rx_entry_t in_ent, head;
  logic      nonempty, full, drop, hold;

  assign in_ent.data = in_data;
  assign in_ent.err  = in_err;

  rtb_ring #(.AW(AW)) u_ring (
    .clk(clk), .rst(rst),
    .push_req(in_valid), .push_ent(in_ent),
    .pop_req(out_ready), .head_ent(head),
    .not_empty(nonempty), .is_full(full),
    .level(fill_level), .dropped(drop)
  );

  rtb_flow #(.CW(CW)) u_flow (
    .clk(clk), .rst(rst), .mode_sw(mode_sw),
    .level(fill_level), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .req_ack(xreq_ack), .hold_q(hold),
    .req_valid(xreq_valid), .req_char(xreq_char)
  );

  assign out_valid = nonempty;
  assign out_data  = head.data;
  assign out_err   = head.err;
  assign cts_stop  = hold && !mode_sw;

  always_ff @(posedge clk) begin
    if (rst)              overrun <= 1'b0;
    else if (drop)        overrun <= 1'b1;
    else if (overrun_clr) overrun <= 1'b0;
  end
endmodule

// File: rtl/rtb_chk.sv
module rtb_chk #(
  parameter int AW = 8,
  localparam int CW = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_sw,
  input logic [CW-1:0] hi_mark,
  input logic          in_valid,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic [2:0]    out_err,
  input logic [CW-1:0] fill_level,
  input logic          cts_stop,
  input logic          xreq_valid,
  input logic [7:0]    xreq_char,
  input logic          xreq_ack,
  input logic          overrun
);
  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_level <= CW'(1 << AW));

  // R3
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fill_level != CW'(1 << AW) && !(out_valid && out_ready))
      |=> fill_level == $past(fill_level) + 1'b1);

  // R2
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  // R4
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fill_level == CW'(1 << AW)) |=> overrun);

  // R6
  pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mode_sw |-> !cts_stop);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xreq_valid && !xreq_ack) |=> xreq_valid);

  // R7
  req_code_chk: assert property (@(posedge clk) disable iff (rst)
    xreq_valid |-> (xreq_char == 8'h13 || xreq_char == 8'h11));

  // R5
  stop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(cts_stop) && $past(!mode_sw) && !mode_sw) |-> $past(fill_level) >= $past(hi_mark));
endmodule

bind rx_throttle_buf rtb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mode_sw(mode_sw), .hi_mark(hi_mark),
  .in_valid(in_valid), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_err(out_err), .fill_level(fill_level),
  .cts_stop(cts_stop), .xreq_valid(xreq_valid), .xreq_char(xreq_char),
  .xreq_ack(xreq_ack), .overrun(overrun)
);

// File: tb/sim_rx_throttle_buf.sv
`timescale 1ns/1ps
module sim_rx_throttle_buf;
  logic       clk = 1'b0;
  logic       rst, mode_sw, in_valid, out_ready, xreq_ack, overrun_clr;
  logic [8:0] hi_mark, lo_mark, fill_level;
  logic [7:0] in_data, out_data, xreq_char;
  logic [2:0] in_err, out_err;
  logic       out_valid, cts_stop, xreq_valid, overrun;

  always #4 clk = ~clk;

  rx_throttle_buf u0 (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  logic [10:0] mq[$];
  bit       m_hold, m_xv, m_ovr;
  logic [7:0] m_xc;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit next_hold(bit h, int lvl, int hi, int lo);
    if (h) return !(lvl <= lo);
    return lvl >= hi;
  endfunction

  task automatic compare();
    chk(fill_level == 9'(mq.size()), "R3 fill_level", fill_level, mq.size());
    chk(out_valid == (mq.size() != 0), "R2 out_valid", out_valid, mq.size() != 0);
    if (mq.size() != 0)
      chk({out_err, out_data} == mq[0], "R2/R8 head entry", {out_err, out_data}, mq[0]);
    chk(cts_stop == (m_hold && !mode_sw), "R5 cts_stop", cts_stop, m_hold && !mode_sw);
    chk(xreq_valid == m_xv, "R6 xreq_valid", xreq_valid, m_xv);
    if (m_xv) chk(xreq_char == m_xc, "R7 xreq_char", xreq_char, m_xc);
    chk(overrun == m_ovr, "R4 overrun", overrun, m_ovr);
  endtask

  task automatic run_phase(int n, int p_in, int p_out, int p_ack, int p_clr);
    for (int i = 0; i < n; i++) begin
      int sz;
      bit hn;
      @(negedge clk);
      compare();
      in_valid    = ($urandom % 100) < p_in;
      in_data     = 8'($urandom);
      in_err      = 3'($urandom);
      out_ready   = ($urandom % 100) < p_out;
      xreq_ack    = ($urandom % 100) < p_ack;
      overrun_clr = ($urandom % 100) < p_clr;
      sz = mq.size();
      hn = next_hold(m_hold, sz, hi_mark, lo_mark);
      @(posedge clk);
      #1;
      if (mode_sw && hn != m_hold) begin
        m_xv = 1'b1;
        m_xc = hn ? 8'h13 : 8'h11;
      end else if (m_xv && xreq_ack) m_xv = 1'b0;
      m_hold = hn;
      if (in_valid && sz == 256) m_ovr = 1'b1;
      else if (overrun_clr) m_ovr = 1'b0;
      if (out_ready && sz > 0) void'(mq.pop_front());
      if (in_valid && sz < 256) mq.push_back({in_err, in_data});
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; mode_sw = 1'b0; hi_mark = 9'd200; lo_mark = 9'd64;
    in_valid = 0; in_data = 0; in_err = 0; out_ready = 0; xreq_ack = 0; overrun_clr = 0;
    m_hold = 0; m_xv = 0; m_ovr = 0; m_xc = 8'h11;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state at the ports
    @(negedge clk);
    chk(fill_level == 0 && !out_valid && !cts_stop && !xreq_valid && !overrun,
        "R1 reset state", {fill_level, out_valid, cts_stop, xreq_valid, overrun}, 0);
    // R8: balanced traffic wraps the positions many times
    run_phase(1500, 60, 58, 0, 0);
    // R4 R5: fill to capacity, drops, hysteresis band
    run_phase(700, 90, 8, 0, 0);
    run_phase(30, 0, 0, 0, 30);
    run_phase(30, 100, 0, 0, 50);
    run_phase(700, 10, 90, 0, 0);
    // R6 R7: character mode, close marks, slow acknowledge
    mode_sw = 1'b1; hi_mark = 9'd4; lo_mark = 9'd3;
    run_phase(1500, 50, 50, 20, 0);
    hi_mark = 9'd120; lo_mark = 9'd16;
    run_phase(1500, 70, 45, 60, 0);
    run_phase(600, 20, 80, 100, 0);
    // back to pin mode
    mode_sw = 1'b0;
    run_phase(800, 75, 40, 0, 10);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule